// File: doc/BRIEF.md
# Local Interrupt Priority Selector

This block picks the one local interrupt a hart should take next. It takes the pending and enable vectors, a delegation mask, the current privilege level and the global enable bits for machine and supervisor level. It returns a valid flag and the cause number of the winner. An interrupt may only compete when the global enable of the level it goes to allows it. Among the interrupts that may compete, the lowest bit index wins.

When the hart runs a guest (virtualization input high), the selection has two tiers. Hypervisor-level interrupts come first. They are gated only by the hypervisor's own supervisor enable bit. If one of them wins, a force-to-hypervisor flag is raised next to the cause. If none wins, only the three guest interrupt lines (software, timer, external) may compete, and they pass through the normal delegation gating.

All three outputs come from flops. They show the decision for the inputs sampled at the previous rising clock edge.

Top module: `local_irq_select`

## Requirements
- R1: A synchronous active-high reset clears `irq_valid_o`, `force_hs_o` and `irq_cause_o` to zero at the next rising edge, whatever the inputs are.
- R2: The outputs change only at a rising edge. They show the decision for the inputs sampled at that edge, so the latency is one cycle.
- R3: An interrupt is a candidate only when its pending bit and its enable bit are both set. Vector bits 12 to 15 are never candidates.
- R4: Privilege is encoded as U=0, S=1, M=3. A non-delegated candidate (delegation bit 0) is eligible when the privilege is not M, or when it is M and `m_glob_ie_i` is 1.
- R5: A delegated candidate (delegation bit 1) is eligible when the privilege is U, or when it is S and `s_glob_ie_i` is 1. At M it is never eligible.
- R6: Among the eligible interrupts, the one with the lowest bit index is reported on `irq_cause_o`, and `irq_valid_o` is set.
- R7: When no interrupt is eligible, `irq_valid_o`, `force_hs_o` and `irq_cause_o` are all 0.
- R8: With `virt_on_i` low, the guest interrupt bits 2, 6 and 10 are never selected, and `force_hs_o` stays 0.
- R9: With `virt_on_i` high, a non-guest candidate is eligible when the privilege is U, or when it is S and `hs_s_glob_ie_i` is 1. Delegation plays no part here. If any such candidate exists, the lowest one is reported and `force_hs_o` is 1.
- R10: With `virt_on_i` high and no R9 winner, only the guest bits 2, 6 and 10 compete. They are gated as in R4 and R5, and `force_hs_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pend_i | input | 16 | Pending interrupt vector |
| en_i | input | 16 | Interrupt enable vector |
| deleg_i | input | 16 | Delegation mask, 1 = goes to supervisor level |
| priv_i | input | 2 | Current privilege (U=0, S=1, M=3) |
| m_glob_ie_i | input | 1 | Machine-level global interrupt enable |
| s_glob_ie_i | input | 1 | Supervisor-level global interrupt enable |
| hs_s_glob_ie_i | input | 1 | Hypervisor's own supervisor global enable |
| virt_on_i | input | 1 | Hart is running a guest |
| irq_valid_o | output | 1 | An interrupt was selected |
| irq_cause_o | output | 5 | Cause number of the selected interrupt |
| force_hs_o | output | 1 | Winner must be taken at hypervisor level |

## Verification
Single-bit vectors are driven at each privilege level with each global enable on and off. This separates the machine-level gate from the supervisor-level gate, and shows that delegation switches between them. Multi-bit vectors with partial enables show whether the lowest-index rule acts on the gated set or on the raw pending set. Vectors that mix guest and hypervisor bits are applied with virtualization on and off. These tell the two tiers apart, show when the force flag is raised, and show that guest bits are excluded outside a guest. Reset during activity and a look at the outputs between edges confirm the register stage.

// File: rtl/lis_pkg.sv
package lis_pkg;
  typedef enum logic [1:0] {
    PRIV_U   = 2'd0,
    PRIV_S   = 2'd1,
    PRIV_RSV = 2'd2,
    PRIV_M   = 2'd3
  } priv_e;

  localparam int unsigned VEC_W_DEF   = 16;
  localparam int unsigned CAUSE_W_DEF = 5;
  // guest software, timer and external lines
  localparam logic [15:0] GUEST_MASK_DEF = 16'h0444;
  // interrupt lines that exist; upper ones are ignored
  localparam logic [15:0] LIVE_MASK_DEF  = 16'h0FFF;
endpackage

// File: rtl/lis_gate.sv
module lis_gate
  import lis_pkg::*;
#(
  parameter int unsigned   VEC_W      = VEC_W_DEF,
  parameter logic [VEC_W-1:0] GUEST_MASK = GUEST_MASK_DEF[VEC_W-1:0],
  parameter logic [VEC_W-1:0] LIVE_MASK  = LIVE_MASK_DEF[VEC_W-1:0]
) (
  input  logic [VEC_W-1:0] pend,
  input  logic [VEC_W-1:0] en,
  input  logic [VEC_W-1:0] deleg,
  input  logic [1:0]       priv,
  input  logic             m_ie,
  input  logic             s_ie,
  input  logic             hs_ie,
  input  logic             virt_on,
  output logic [VEC_W-1:0] host_vec,
  output logic [VEC_W-1:0] norm_vec
);
  logic [VEC_W-1:0] cand;
  logic [VEC_W-1:0] base;
  logic             m_open;
  logic             s_open;
  logic             host_open;
  priv_e            lvl;

  always_comb begin
    lvl       = priv_e'(priv);
    cand      = pend & en & LIVE_MASK;
    m_open    = (lvl != PRIV_M) || m_ie;
    s_open    = (lvl == PRIV_U) || ((lvl == PRIV_S) && s_ie);
    host_open = (lvl == PRIV_U) || ((lvl == PRIV_S) && hs_ie);
    if (virt_on) begin
      host_vec = cand & ~GUEST_MASK & {VEC_W{host_open}};
      base     = cand & GUEST_MASK;
    end else begin
      host_vec = '0;
      base     = cand & ~GUEST_MASK;
    end
    norm_vec = (base & ~deleg & {VEC_W{m_open}}) |
               (base &  deleg & {VEC_W{s_open}});
  end
endmodule

// File: rtl/lis_lsb_pick.sv
module lis_lsb_pick #(
  parameter int unsigned W     = 16,
  parameter int unsigned IDX_W = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]     vec,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  logic [W-1:0] lowest;

  assign lowest = vec & (~vec + W'(1));
  assign found  = |vec;

  for (genvar b = 0; b < IDX_W; b++) begin : g_bit
    logic [W-1:0] sel;
    always_comb begin
      for (int i = 0; i < W; i++) sel[i] = ((i >> b) & 1) != 0;
    end
    assign idx[b] = |(lowest & sel);
  end
endmodule

// File: rtl/local_irq_select.sv
module local_irq_select
  import lis_pkg::*;
#(
  parameter int unsigned      VEC_W      = VEC_W_DEF,
  parameter int unsigned      CAUSE_W    = CAUSE_W_DEF,
  parameter logic [VEC_W-1:0] GUEST_MASK = GUEST_MASK_DEF[VEC_W-1:0],
  parameter logic [VEC_W-1:0] LIVE_MASK  = LIVE_MASK_DEF[VEC_W-1:0]
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [VEC_W-1:0]   pend_i,
  input  logic [VEC_W-1:0]   en_i,
  input  logic [VEC_W-1:0]   deleg_i,
  input  logic [1:0]         priv_i,
  input  logic               m_glob_ie_i,
  input  logic               s_glob_ie_i,
  input  logic               hs_s_glob_ie_i,
  input  logic               virt_on_i,
  output logic               irq_valid_o,
  output logic [CAUSE_W-1:0] irq_cause_o,
  output logic               force_hs_o
);
  localparam int unsigned IDX_W = (VEC_W > 1) ? $clog2(VEC_W) : 1;

  logic [VEC_W-1:0] host_vec;
  logic [VEC_W-1:0] norm_vec;
  logic             host_hit;
  logic             norm_hit;
  logic [IDX_W-1:0] host_idx;
  logic [IDX_W-1:0] norm_idx;
  logic             nxt_valid;
  logic             nxt_force;
  logic [CAUSE_W-1:0] nxt_cause;

  lis_gate #(
    .VEC_W(VEC_W), .GUEST_MASK(GUEST_MASK), .LIVE_MASK(LIVE_MASK)
  ) u_gate (
    .pend(pend_i), .en(en_i), .deleg(deleg_i), .priv(priv_i),
    .m_ie(m_glob_ie_i), .s_ie(s_glob_ie_i), .hs_ie(hs_s_glob_ie_i),
    .virt_on(virt_on_i), .host_vec(host_vec), .norm_vec(norm_vec)
  );

  lis_lsb_pick #(.W(VEC_W), .IDX_W(IDX_W)) u_pick_host (
    .vec(host_vec), .found(host_hit), .idx(host_idx)
  );

  lis_lsb_pick #(.W(VEC_W), .IDX_W(IDX_W)) u_pick_norm (
    .vec(norm_vec), .found(norm_hit), .idx(norm_idx)
  );

  always_comb begin
    nxt_valid = host_hit | norm_hit;
    nxt_force = host_hit;
    if (host_hit)      nxt_cause = CAUSE_W'(host_idx);
    else if (norm_hit) nxt_cause = CAUSE_W'(norm_idx);
    else               nxt_cause = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_valid_o <= 1'b0;
      force_hs_o  <= 1'b0;
      irq_cause_o <= '0;
    end else begin
      irq_valid_o <= nxt_valid;
      force_hs_o  <= nxt_force;
      irq_cause_o <= nxt_cause;
    end
  end
endmodule

// File: rtl/lis_chk.sv
module lis_chk #(
  parameter int unsigned      VEC_W      = 16,
  parameter int unsigned      CAUSE_W    = 5,
  parameter logic [VEC_W-1:0] GUEST_MASK = 16'h0444,
  parameter logic [VEC_W-1:0] LIVE_MASK  = 16'h0FFF
) (
  input logic               clk,
  input logic               rst,
  input logic [VEC_W-1:0]   pend_i,
  input logic [VEC_W-1:0]   en_i,
  input logic               virt_on_i,
  input logic               irq_valid_o,
  input logic [CAUSE_W-1:0] irq_cause_o,
  input logic               force_hs_o
);
  logic [VEC_W-1:0] live_cand;
  assign live_cand = pend_i & en_i & LIVE_MASK;

  // R1
  rst_clears_chk: assert property (@(posedge clk)
    rst |=> (!irq_valid_o && !force_hs_o && irq_cause_o == '0));

  // R3
  winner_was_cand_chk: assert property (@(posedge clk) disable iff (rst)
    irq_valid_o |-> (($past(live_cand) >> irq_cause_o) & VEC_W'(1)) != '0);

  // R7
  none_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (live_cand == '0) |=> (!irq_valid_o && !force_hs_o && irq_cause_o == '0));

  // R8
  host_off_no_force_chk: assert property (@(posedge clk) disable iff (rst)
    !virt_on_i |=> !force_hs_o);

  // R8
  host_off_no_guest_chk: assert property (@(posedge clk) disable iff (rst)
    !virt_on_i |=> !(irq_valid_o && ((GUEST_MASK >> irq_cause_o) & VEC_W'(1)) != '0));

  // R9
  force_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
    force_hs_o |-> irq_valid_o);
endmodule

bind local_irq_select lis_chk #(
  .VEC_W(VEC_W), .CAUSE_W(CAUSE_W), .GUEST_MASK(GUEST_MASK), .LIVE_MASK(LIVE_MASK)
) u_lis_chk (
  .clk(clk), .rst(rst), .pend_i(pend_i), .en_i(en_i), .virt_on_i(virt_on_i),
  .irq_valid_o(irq_valid_o), .irq_cause_o(irq_cause_o), .force_hs_o(force_hs_o)
);

// File: tb/local_irq_select_tb.sv
module local_irq_select_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] pend_i = '0;
  logic [15:0] en_i = '0;
  logic [15:0] deleg_i = '0;
  logic [1:0]  priv_i = '0;
  logic        m_glob_ie_i = 1'b0;
  logic        s_glob_ie_i = 1'b0;
  logic        hs_s_glob_ie_i = 1'b0;
  logic        virt_on_i = 1'b0;
  logic        irq_valid_o;
  logic [4:0]  irq_cause_o;
  logic        force_hs_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  local_irq_select dut_i (
    .clk(clk), .rst(rst), .pend_i(pend_i), .en_i(en_i), .deleg_i(deleg_i),
    .priv_i(priv_i), .m_glob_ie_i(m_glob_ie_i), .s_glob_ie_i(s_glob_ie_i),
    .hs_s_glob_ie_i(hs_s_glob_ie_i), .virt_on_i(virt_on_i),
    .irq_valid_o(irq_valid_o), .irq_cause_o(irq_cause_o), .force_hs_o(force_hs_o)
  );

  task automatic expect_out(input string req, input bit ev, input bit ef, input int ec);
    checks++;
    if (irq_valid_o !== ev || force_hs_o !== ef || irq_cause_o !== 5'(ec)) begin
      errors++;
      $display("FAIL %s: got valid=%0b force=%0b cause=%0d, expected valid=%0b force=%0b cause=%0d",
               req, irq_valid_o, force_hs_o, irq_cause_o, ev, ef, ec);
    end
  endtask

  // drive at a falling edge, let one rising edge pass, sample at the next falling edge
  task automatic apply(input logic [15:0] p, input logic [15:0] e, input logic [15:0] d,
                       input logic [1:0] pv, input bit mie, input bit sie,
                       input bit hsie, input bit vo);
    pend_i = p; en_i = e; deleg_i = d; priv_i = pv;
    m_glob_ie_i = mie; s_glob_ie_i = sie; hs_s_glob_ie_i = hsie; virt_on_i = vo;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (2) @(negedge clk);
    expect_out("R1 after reset", 0, 0, 0);
    rst = 1'b0;
    apply(16'h0080, 16'hFFFF, 16'h0, 2'd0, 0, 0, 0, 0);
    expect_out("R1 active before reset", 1, 0, 7);
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    expect_out("R1 reset mid-run", 0, 0, 0);
    rst = 1'b0;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic t_latency();
    apply(16'h0010, 16'hFFFF, 16'h0, 2'd0, 0, 0, 0, 0);
    expect_out("R2 first value", 1, 0, 4);
    pend_i = 16'h0100;
    #1;
    expect_out("R2 held between edges", 1, 0, 4);
    @(posedge clk); @(negedge clk);
    expect_out("R2 updated after edge", 1, 0, 8);
  endtask

  task automatic t_candidate();
    apply(16'h0080, 16'h0000, 16'h0, 2'd0, 0, 0, 0, 0);
    expect_out("R3 pending without enable", 0, 0, 0);
    apply(16'hF000, 16'hFFFF, 16'h0, 2'd0, 1, 1, 0, 0);
    expect_out("R3 upper bits ignored", 0, 0, 0);
    apply(16'h0000, 16'hFFFF, 16'h0, 2'd0, 1, 1, 0, 0);
    expect_out("R7 nothing pending", 0, 0, 0);
  endtask

  task automatic t_machine_gate();
    apply(16'h0008, 16'hFFFF, 16'h0, 2'd3, 0, 1, 0, 0);
    expect_out("R4 M level, m enable off", 0, 0, 0);
    apply(16'h0008, 16'hFFFF, 16'h0, 2'd3, 1, 0, 0, 0);
    expect_out("R4 M level, m enable on", 1, 0, 3);
    apply(16'h0008, 16'hFFFF, 16'h0, 2'd1, 0, 0, 0, 0);
    expect_out("R4 S level below M", 1, 0, 3);
  endtask

  task automatic t_super_gate();
    apply(16'h0020, 16'hFFFF, 16'h0020, 2'd1, 1, 0, 0, 0);
    expect_out("R5 S level, s enable off", 0, 0, 0);
    apply(16'h0020, 16'hFFFF, 16'h0020, 2'd1, 1, 1, 0, 0);
    expect_out("R5 S level, s enable on", 1, 0, 5);
    apply(16'h0020, 16'hFFFF, 16'h0020, 2'd0, 0, 0, 0, 0);
    expect_out("R5 U level", 1, 0, 5);
    apply(16'h0020, 16'hFFFF, 16'h0020, 2'd3, 1, 1, 0, 0);
    expect_out("R5 M level blocks delegated", 0, 0, 0);
  endtask

  task automatic t_priority();
    apply(16'h00A8, 16'hFFFF, 16'h0, 2'd0, 0, 0, 0, 0);
    expect_out("R6 lowest of three", 1, 0, 3);
    apply(16'h00A8, 16'h00A0, 16'h0, 2'd0, 0, 0, 0, 0);
    expect_out("R6 lowest after enable", 1, 0, 5);
    apply(16'h000A, 16'hFFFF, 16'h0002, 2'd3, 1, 1, 0, 0);
    expect_out("R6 lowest eligible, not lowest pending", 1, 0, 3);
  endtask

  task automatic t_no_guest();
    apply(16'h0444, 16'hFFFF, 16'h0, 2'd0, 1, 1, 1, 0);
    expect_out("R8 guest bits excluded", 0, 0, 0);
    apply(16'h0C44, 16'hFFFF, 16'h0, 2'd0, 1, 1, 1, 0);
    expect_out("R8 non-guest chosen", 1, 0, 11);
  endtask

  task automatic t_guest();
    apply(16'h0204, 16'hFFFF, 16'h0, 2'd0, 0, 0, 0, 1);
    expect_out("R9 host tier wins at U", 1, 1, 9);
    apply(16'h0240, 16'hFFFF, 16'hFFFF, 2'd1, 0, 1, 0, 1);
    expect_out("R10 host gated, guest chosen", 1, 0, 6);
    apply(16'h0240, 16'hFFFF, 16'hFFFF, 2'd1, 0, 1, 1, 1);
    expect_out("R9 host enable on at S", 1, 1, 9);
    apply(16'h0200, 16'hFFFF, 16'h0, 2'd3, 1, 1, 1, 1);
    expect_out("R9 host tier closed at M", 0, 0, 0);
    apply(16'h0040, 16'hFFFF, 16'h0, 2'd1, 0, 0, 0, 1);
    expect_out("R10 guest non-delegated at S", 1, 0, 6);
    apply(16'h0040, 16'hFFFF, 16'h0040, 2'd1, 1, 0, 1, 1);
    expect_out("R10 guest delegated, s enable off", 0, 0, 0);
  endtask

  initial begin
    t_reset();
    t_latency();
    t_candidate();
    t_machine_gate();
    t_super_gate();
    t_priority();
    t_no_guest();
    t_guest();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule